// File: doc/BRIEF.md
# Three-Phase Dead-Time Generator

This block sits between a three-phase PWM source and the six gate drivers of a bridge. Each phase input is a complementary command. When it is high the upper switch of that leg should conduct, and when it is low the lower switch should. Every time a phase input changes level, the block turns off the switch that was conducting at once. It holds both switches of that leg off for a non-overlap interval, then turns on the switch that matches the new level. This keeps the two switches of a leg from conducting at the same instant.

All three legs use one shared configuration word, written through a simple write port. It holds an 8-bit dead-time compare value and a 2-bit tick-rate select. The tick rate is one, two, four or eight machine cycles. At the one-cycle rate the interval is the compare value plus one, so the shortest possible dead time is two cycles. At the slower rates it is the compare value times the tick period. A compare value of zero is illegal: it raises an error flag and blocks the leg rather than giving zero dead time. Each leg captures the configuration at its own input edge, so a write never stretches or cuts an interval that is already running.

Top module: `tri_deadtime_gen`

## Requirements
- R1: For every phase, the upper and lower outputs are never both high in the same cycle.
- R2: When a clock edge first samples a new level on a phase input, the output that was high goes low at that same edge (one register stage).
- R3: Once the interval ends, the upper output of a phase is high when the phase input is 1, and the lower output is high when it is 0.
- R4: With tick select 2'b00 and compare value N ≥ 1, the new output rises N+1 cycles after the edge that sampled the input change.
- R5: With tick select 2'b01, 2'b10 or 2'b11 and compare value N ≥ 1, the new output rises N×2, N×4 or N×8 cycles after that edge.
- R6: The shortest dead time is two cycles (N=1, select 2'b00). A one-cycle dead time cannot occur.
- R7: If a phase input changes again before its interval ends, the interval restarts from the new edge, and both outputs of the phase stay low for a full interval.
- R8: A configuration write made during a running interval does not change that interval. It applies from the next input edge.
- R9: The error flag is high from the cycle after a write with compare value 0, and low after a write with a nonzero value. An input edge taken while the compare value is 0 holds both outputs of that phase low until the next input edge.
- R10: The configuration word carries the compare value in bits [15:8] and the tick select in bits [1:0]. Bits [7:2] are ignored. After reset the compare value is 1 and the select is 2'b00.
- R11: After reset all six outputs are low and the error flag is low. A phase with no input edge since reset keeps both of its outputs low.
- R12: An edge on one phase does not change the outputs of the other phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word: compare value [15:8], tick select [1:0] |
| pwm_in | input | 3 | Complementary command, one bit per phase |
| gate_hi | output | 3 | Upper switch drive, one bit per phase |
| gate_lo | output | 3 | Lower switch drive, one bit per phase |
| cfg_err | output | 1 | High while the stored compare value is zero |

## Verification
The bench measures the exact dead time at both ends of the compare range and for every tick select. A design that applied the one-cycle rule to the slower rates, or forgot the +1 at the fastest rate, would miss the expected count by exactly one tick. It retriggers a phase in the middle of an interval: a design that let the old interval run out would turn on the new output too early, or would briefly drive the old output again. It rewrites the configuration during an interval and expects the old length. It loads a zero compare value and expects both outputs of that leg to stay low; a design that took zero literally would switch the new output on at once. It also checks that the ignored middle bits of the word and an edge on a neighbouring phase leave everything else unchanged.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int CMP_W   = 8;
    localparam int SEL_W   = 2;
    localparam int CFG_W   = 16;
    localparam int CMP_LSB = 8;
    localparam int SEL_LSB = 0;
    localparam int PRE_W   = (1 << SEL_W) - 1;
    localparam int CNT_W   = CMP_W + 1;

    typedef enum logic [SEL_W-1:0] {
        TICK_1 = 2'd0,
        TICK_2 = 2'd1,
        TICK_4 = 2'd2,
        TICK_8 = 2'd3
    } tick_sel_e;

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        tick_sel_e        sel;
    } dt_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DEAD,
        PH_BLOCK,
        PH_DRIVE
    } ph_state_e;

    // Number of ticks to count for one interval.
    function automatic logic [CNT_W-1:0] load_ticks(input dt_cfg_t c);
        logic [CNT_W-1:0] base;
        base = {1'b0, c.cmp};
        return (c.sel == TICK_1) ? base + CNT_W'(1) : base;
    endfunction

    // Terminal value of the per-phase prescaler.
    function automatic logic [PRE_W-1:0] tick_mask(input tick_sel_e s);
        return PRE_W'((32'd1 << s) - 32'd1);
    endfunction

endpackage

// File: rtl/dtg_cfg_reg.sv
module dtg_cfg_reg
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output dt_cfg_t          cfg,
    output logic             err
);

    localparam logic [CFG_W-1:0] FIELD_MASK =
        (CFG_W'((1 << CMP_W) - 1) << CMP_LSB) |
        (CFG_W'((1 << SEL_W) - 1) << SEL_LSB);

    dt_cfg_t cfg_q;

    // Middle bits of the word carry nothing.
    logic [CFG_W-1:0] spare_unused;
    assign spare_unused = wdata & ~FIELD_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.cmp <= CMP_W'(1);
            cfg_q.sel <= TICK_1;
        end else if (we) begin
            cfg_q.cmp <= wdata[CMP_LSB +: CMP_W];
            cfg_q.sel <= tick_sel_e'(wdata[SEL_LSB +: SEL_W]);
        end
    end

    assign cfg = cfg_q;
    assign err = (cfg_q.cmp == '0);

endmodule

// File: rtl/dtg_prescale.sv
module dtg_prescale
    import dtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      run,
    input  tick_sel_e sel,
    output logic      tick
);

    logic [PRE_W-1:0] pre_q;

    assign tick = run && (pre_q == tick_mask(sel));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/dtg_phase.sv
module dtg_phase
    import dtg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pwm,
    input  dt_cfg_t cfg,
    output logic    hi,
    output logic    lo
);

    ph_state_e        st_q;
    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;
    tick_sel_e        sel_q;
    logic             hi_q;
    logic             lo_q;
    logic             chg;
    logic             tick;

    assign chg = (pwm != lvl_q);

    dtg_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (chg),
        .run     (st_q == PH_DEAD),
        .sel     (sel_q),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_IDLE;
            lvl_q <= 1'b0;
            cnt_q <= '0;
            sel_q <= TICK_1;
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
        end else if (chg) begin
            // New level: blank both sides, snapshot the configuration.
            lvl_q <= pwm;
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
            sel_q <= cfg.sel;
            cnt_q <= load_ticks(cfg);
            st_q  <= (cfg.cmp == '0) ? PH_BLOCK : PH_DEAD;
        end else if (st_q == PH_DEAD && tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
                st_q <= PH_DRIVE;
                hi_q <= lvl_q;
                lo_q <= ~lvl_q;
            end
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/tri_deadtime_gen.sv
module tri_deadtime_gen
    import dtg_pkg::*;
#(
    parameter int PHASES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [PHASES-1:0] pwm_in,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo,
    output logic              cfg_err
);

    dt_cfg_t cfg;

    dtg_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .err   (cfg_err)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        dtg_phase u_leg (
            .clk (clk),
            .rst (rst),
            .pwm (pwm_in[p]),
            .cfg (cfg),
            .hi  (gate_hi[p]),
            .lo  (gate_lo[p])
        );
    end

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
#(
    parameter int PHASES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CMP_W-1:0]  wr_cmp,
    input logic [PHASES-1:0] pwm_in,
    input logic [PHASES-1:0] gate_hi,
    input logic [PHASES-1:0] gate_lo,
    input logic              cfg_err
);

    // R9: error flag follows the written compare value
    a_r9_err_follows_write: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_err == ($past(wr_cmp) == '0)));

    for (genvar p = 0; p < PHASES; p++) begin : g_chk
        // R1: never both switches of a leg
        a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst)
            !(gate_hi[p] && gate_lo[p]));

        // R2: an input change blanks the leg at the sampling edge
        a_r2_edge_blanks: assert property (@(posedge clk) disable iff (rst)
            (pwm_in[p] != $past(pwm_in[p])) |=> (!gate_hi[p] && !gate_lo[p]));

        // R3: upper side only for a high command
        a_r3_hi_matches_level: assert property (@(posedge clk) disable iff (rst)
            gate_hi[p] |-> $past(pwm_in[p]));

        // R3: lower side only for a low command
        a_r3_lo_matches_level: assert property (@(posedge clk) disable iff (rst)
            gate_lo[p] |-> !$past(pwm_in[p]));

        // R6: at least two blanked cycles after any change
        a_r6_min_two_cycles: assert property (@(posedge clk) disable iff (rst)
            (pwm_in[p] != $past(pwm_in[p])) |=>
                (!gate_hi[p] && !gate_lo[p]) ##1 (!gate_hi[p] && !gate_lo[p]));
    end

endmodule

bind tri_deadtime_gen dtg_checker #(.PHASES(PHASES)) u_dtg_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .wr_cmp  (cfg_wdata[dtg_pkg::CMP_LSB +: dtg_pkg::CMP_W]),
    .pwm_in  (pwm_in),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .cfg_err (cfg_err)
);

// File: tb/tri_deadtime_gen_tb_top.sv
`timescale 1ns/1ps
module tri_deadtime_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  pwm_in = '0;
    logic [2:0]  gate_hi;
    logic [2:0]  gate_lo;
    logic        cfg_err;

    int vecs = 0;
    int bad  = 0;

    always #2.5 clk = ~clk;

    tri_deadtime_gen #(.PHASES(3)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .pwm_in    (pwm_in),
        .gate_hi   (gate_hi),
        .gate_lo   (gate_lo),
        .cfg_err   (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] cmp, input logic [1:0] sel);
        write_word({cmp, 6'b0, sel});
    endtask

    // n counts posedges since the input was driven; active first at n = D+1.
    task automatic count_active(input int ph, input bit lvl, input int n0,
                                input int lim, output int n);
        bit overlap = 1'b0;
        bit stale   = 1'b0;
        bit act;
        n = n0;
        forever begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (gate_hi[ph] && gate_lo[ph]) overlap = 1'b1;
            if (lvl ? gate_lo[ph] : gate_hi[ph]) stale = 1'b1;
            act = lvl ? gate_hi[ph] : gate_lo[ph];
            if (act || n > lim) break;
        end
        check(!overlap, "R1 overlap during interval", int'(overlap), 0);
        check(!stale, "R2 old side still driven", int'(stale), 0);
    endtask

    task automatic measure(input int ph, input bit lvl, input int exp_d, input string req);
        int n;
        @(negedge clk);
        pwm_in[ph] = lvl;
        count_active(ph, lvl, 0, exp_d + 20, n);
        check(n - 1 == exp_d, req, n - 1, exp_d);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(gate_hi == 3'b0 && gate_lo == 3'b0, "R11 outputs after reset",
              int'({gate_hi, gate_lo}), 0);
        check(cfg_err == 1'b0, "R11 error flag after reset", int'(cfg_err), 0);
        repeat (3) @(negedge clk);
        check(gate_hi == 3'b0 && gate_lo == 3'b0, "R11 idle without edge",
              int'({gate_hi, gate_lo}), 0);
    endtask

    task automatic t_fast_rate();
        measure(0, 1'b1, 2, "R6 R10 reset config N=1 gives 2");
        write_cfg(8'd5, 2'b00);
        measure(0, 1'b0, 6, "R4 R3 falling N=5 sel0");
        write_cfg(8'd255, 2'b00);
        measure(0, 1'b1, 256, "R4 N=255 sel0");
    endtask

    task automatic t_slow_rates();
        write_cfg(8'd3, 2'b01);
        measure(1, 1'b1, 6, "R5 N=3 sel1");
        write_cfg(8'd2, 2'b10);
        measure(1, 1'b0, 8, "R5 N=2 sel2");
        write_cfg(8'd4, 2'b11);
        measure(1, 1'b1, 32, "R5 N=4 sel3");
        write_cfg(8'd255, 2'b11);
        measure(1, 1'b0, 2040, "R5 N=255 sel3");
    endtask

    task automatic t_retrigger();
        bit seen = 1'b0;
        write_cfg(8'd9, 2'b00);
        @(negedge clk);
        pwm_in[2] = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (gate_hi[2] || gate_lo[2]) seen = 1'b1;
        end
        check(!seen, "R7 blank before retrigger", int'(seen), 0);
        measure(2, 1'b0, 10, "R7 full interval from retrigger");
    endtask

    task automatic t_midwrite();
        int n;
        write_cfg(8'd4, 2'b00);
        @(negedge clk);
        pwm_in[0] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {8'd20, 6'b0, 2'b01};
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        check(!gate_hi[0] && !gate_lo[0], "R8 blank at write",
              int'({gate_hi[0], gate_lo[0]}), 0);
        count_active(0, 1'b0, 2, 60, n);
        check(n - 1 == 5, "R8 running interval keeps old length", n - 1, 5);
        measure(0, 1'b1, 40, "R8 new config at next edge");
    endtask

    task automatic t_zero();
        bit seen = 1'b0;
        write_cfg(8'd0, 2'b00);
        check(cfg_err == 1'b1, "R9 flag on zero compare", int'(cfg_err), 1);
        @(negedge clk);
        pwm_in[1] = 1'b1;
        repeat (300) begin
            @(negedge clk);
            if (gate_hi[1] || gate_lo[1]) seen = 1'b1;
        end
        check(!seen, "R9 zero compare holds leg off", int'(seen), 0);
        write_cfg(8'd3, 2'b00);
        check(cfg_err == 1'b0, "R9 flag clears", int'(cfg_err), 0);
        repeat (5) @(negedge clk);
        check(!gate_hi[1] && !gate_lo[1], "R9 still off until next edge",
              int'({gate_hi[1], gate_lo[1]}), 0);
        measure(1, 1'b0, 4, "R9 legal value at next edge");
    endtask

    task automatic t_fields();
        write_word(16'h02FE);
        measure(2, 1'b1, 8, "R10 middle bits ignored, sel in [1:0]");
    endtask

    task automatic t_independent();
        logic [2:0] hi0, lo0;
        hi0 = gate_hi;
        lo0 = gate_lo;
        measure(2, 1'b0, 8, "R12 own phase timing");
        check(gate_hi[1:0] == hi0[1:0] && gate_lo[1:0] == lo0[1:0],
              "R12 other phases unchanged",
              int'({gate_hi[1:0], gate_lo[1:0]}), int'({hi0[1:0], lo0[1:0]}));
        check(gate_hi[0] == 1'b1 && gate_lo[1] == 1'b1, "R3 settled levels",
              int'({gate_hi[0], gate_lo[1]}), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vecs++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fast_rate();
        t_slow_rates();
        t_retrigger();
        t_midwrite();
        t_zero();
        t_fields();
        t_independent();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule